// File: doc/BRIEF.md
# Multi-Waveform Chirp Scheduler

This block sequences radar chirps from a single clock domain. On each chirp it presents a 2-bit waveform select (short, medium or long) and a one-clock chirp strobe. Both signals come from registers and go straight to the downstream pulse-compression and clutter-cancelling stages, so no edge detector is needed there. Every chirp is a sub-frame: a transmit phase and then a listen phase, with lengths set per waveform by configuration inputs. A 2-bit mode input selects one of four behaviours. In the first, an external controller's chirp requests are forwarded. In the second, the block scans the enabled sub-frames in turn. In the third, it fires a single chirp for debug. In the fourth, it dwells on a track waveform, and a watchdog hands control back to scanning when the track goes quiet.

A 3-bit enable mask removes waveforms from the scan at run time. The mask is read again at every sub-frame boundary, so changing it takes effect on the next sub-frame without stopping the sequence. A frame marker pulses when a frame completes. The watchdog counts the frames that pass with no track activity.

Top module: `chirp_sequencer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to idle with `chirp_pulse`, `frame_end` and `scan_fallback` low and `wave_sel` = 00. After reset it stays idle until a mode condition starts a chirp.
- R2: `wave_sel` encodes 00 = short, 01 = medium, 10 = long. The code 11 is never driven. A request or a track/debug waveform of 11 starts no chirp.
- R3: In mode 00, each cycle with `ext_req` high and a legal `ext_wave` produces `chirp_pulse` on the next cycle, with `wave_sel` equal to that `ext_wave`. Back-to-back requests give back-to-back pulses, and `sub_en` has no effect in this mode.
- R4: Outside mode 00, `chirp_pulse` is high for exactly one clock, in the first cycle of a chirp. `wave_sel` changes only in a cycle where `chirp_pulse` is high.
- R5: A sub-frame lasts the transmit count plus the listen count of its waveform. In modes 01 and 11 the next chirp starts with no gap. A transmit count of 0 selects the built-in default (short 100, medium 500, long 1000 cycles), and a listen count of 0 counts as 1 cycle.
- R6: In mode 01, `sub_en` bit 0 enables short, bit 1 medium and bit 2 long. From idle the scan starts at the lowest enabled waveform. After each sub-frame it moves to the next enabled waveform in the cyclic order short, medium, long, using the mask value present at that boundary.
- R7: In mode 01 with `sub_en` = 000, no new chirp starts and `chirp_pulse` stays low.
- R8: In mode 10, `debug_go` while idle with a legal `ext_wave` fires exactly one chirp, after which the block returns to idle. A `debug_go` that arrives while a chirp is in progress is ignored.
- R9: `frame_end` pulses for one cycle, on the cycle after the last listen cycle of a frame. In the scan, a frame closes after the highest enabled waveform. In track and debug dwell, every sub-frame is a frame.
- R10: In mode 11 the block chirps `ext_wave` continuously. A `track_hit` clears the idle-frame count. A frame end with no hit increments it. On the 5th consecutive idle frame, `scan_fallback` rises together with `frame_end`, and the next chirp follows the scan order of R6. A `track_hit` or leaving mode 11 clears `scan_fallback`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 2 | 00 forward, 01 scan, 10 debug, 11 track dwell |
| sub_en | input | 3 | Sub-frame enable mask: bit0 short, bit1 medium, bit2 long |
| ext_req | input | 1 | External chirp request (mode 00) |
| ext_wave | input | 2 | Waveform for forwarded, debug and track chirps |
| debug_go | input | 1 | Single-chirp trigger (mode 10) |
| track_hit | input | 1 | Track activity indication |
| cfg_short_tx | input | CNT_W | Short transmit cycles (0 = default) |
| cfg_short_rx | input | CNT_W | Short listen cycles (0 = 1) |
| cfg_med_tx | input | CNT_W | Medium transmit cycles (0 = default) |
| cfg_med_rx | input | CNT_W | Medium listen cycles (0 = 1) |
| cfg_long_tx | input | CNT_W | Long transmit cycles (0 = default) |
| cfg_long_rx | input | CNT_W | Long listen cycles (0 = 1) |
| wave_sel | output | 2 | Registered waveform select |
| chirp_pulse | output | 1 | One-clock chirp start strobe |
| frame_end | output | 1 | One-clock frame completion marker |
| scan_fallback | output | 1 | Watchdog has handed track dwell back to scanning |

## Verification
Every output is a register, so each result is due exactly one cycle after the edge that sees its cause. A forwarded request shows its pulse one cycle after the request. A scan or track chirp shows its pulse, and the preceding frame's `frame_end`, exactly transmit plus listen cycles after the previous pulse. A watchdog fallback shows on the same cycle as the fifth idle frame end. The bench drives inputs and samples outputs one nanosecond after each rising edge. It measures the interval between pulses by stepping one clock at a time, and compares each interval with the sum of the configured lengths, so an off-by-one in any stage shows up as a wrong count.

// File: rtl/chirp_seq_pkg.sv
package chirp_seq_pkg;

  localparam int NUM_WAVES = 3;

  typedef enum logic [1:0] {
    WV_SHORT  = 2'd0,
    WV_MEDIUM = 2'd1,
    WV_LONG   = 2'd2,
    WV_RSVD   = 2'd3
  } wave_t;

  typedef enum logic [1:0] {
    MD_PASS  = 2'd0,
    MD_SCAN  = 2'd1,
    MD_DEBUG = 2'd2,
    MD_TRACK = 2'd3
  } mode_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_TX   = 2'd1,
    PH_RX   = 2'd2
  } phase_t;

  typedef struct packed {
    logic       ok;
    logic [1:0] idx;
  } pick_t;

  // Lowest enabled waveform index in the mask (0 when none).
  function automatic logic [1:0] lowest_on(input logic [NUM_WAVES-1:0] m);
    logic [1:0] r;
    r = 2'd0;
    for (int i = NUM_WAVES - 1; i >= 0; i--) begin
      if (m[i]) r = 2'(i);
    end
    return r;
  endfunction

  // Next enabled waveform after cur, cyclic; cur itself is considered last.
  function automatic pick_t next_on(input logic [NUM_WAVES-1:0] m, input logic [1:0] cur);
    pick_t p;
    int    j;
    p.ok  = 1'b0;
    p.idx = 2'd0;
    for (int k = NUM_WAVES; k >= 1; k--) begin
      j = (int'(cur) + k) % NUM_WAVES;
      if (m[j]) begin
        p.ok  = 1'b1;
        p.idx = 2'(j);
      end
    end
    return p;
  endfunction

  // True when some waveform above cur is enabled.
  function automatic logic any_above(input logic [NUM_WAVES-1:0] m, input logic [1:0] cur);
    logic r;
    r = 1'b0;
    for (int i = 0; i < NUM_WAVES; i++) begin
      if (i > int'(cur) && m[i]) r = 1'b1;
    end
    return r;
  endfunction

endpackage

// File: rtl/chirp_phase_timer.sv
module chirp_phase_timer
  import chirp_seq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             abort,
  input  logic             start,
  input  logic [CNT_W-1:0] tx_len,
  input  logic [CNT_W-1:0] rx_len,
  output phase_t           phase,
  output logic             sub_end
);

  logic [CNT_W-1:0] tmr;

  assign sub_end = (phase == PH_RX) && (tmr == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      tmr   <= '0;
    end else if (abort) begin
      phase <= PH_IDLE;
      tmr   <= '0;
    end else if (start) begin
      phase <= PH_TX;
      tmr   <= tx_len - CNT_W'(1);
    end else begin
      case (phase)
        PH_TX: begin
          if (tmr == '0) begin
            phase <= PH_RX;
            tmr   <= rx_len - CNT_W'(1);
          end else begin
            tmr <= tmr - CNT_W'(1);
          end
        end
        PH_RX: begin
          if (tmr == '0) phase <= PH_IDLE;
          else           tmr   <= tmr - CNT_W'(1);
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/chirp_wave_picker.sv
module chirp_wave_picker
  import chirp_seq_pkg::*;
(
  input  mode_t                  mode,
  input  logic [NUM_WAVES-1:0]   sub_en,
  input  logic                   ext_req,
  input  wave_t                  ext_wave,
  input  logic                   debug_go,
  input  phase_t                 phase,
  input  logic                   sub_end,
  input  wave_t                  cur_wave,
  input  logic                   fb_q,
  input  logic                   fb_now,
  output logic                   start,
  output wave_t                  start_wave,
  output logic                   frame_evt
);

  logic  idle, ext_ok, scan_old, scan_now;
  pick_t nxt;

  assign idle     = (phase == PH_IDLE);
  assign ext_ok   = (ext_wave != WV_RSVD);
  assign scan_old = (mode == MD_SCAN) || ((mode == MD_TRACK) && fb_q);
  assign scan_now = (mode == MD_SCAN) || ((mode == MD_TRACK) && fb_now);
  assign nxt      = next_on(sub_en, cur_wave);

  // Frame closes at every sub-frame end except mid-way through a scan pass.
  assign frame_evt = (mode != MD_PASS) && sub_end &&
                     !(scan_old && any_above(sub_en, cur_wave));

  always_comb begin
    start      = 1'b0;
    start_wave = cur_wave;
    case (mode)
      MD_PASS: begin
        if (ext_req && ext_ok) begin
          start      = 1'b1;
          start_wave = ext_wave;
        end
      end
      MD_DEBUG: begin
        if (idle && debug_go && ext_ok) begin
          start      = 1'b1;
          start_wave = ext_wave;
        end
      end
      default: begin
        if (scan_now) begin
          if (sub_end) begin
            start      = nxt.ok;
            start_wave = wave_t'(nxt.idx);
          end else if (idle && (|sub_en)) begin
            start      = 1'b1;
            start_wave = wave_t'(lowest_on(sub_en));
          end
        end else if ((idle || sub_end) && ext_ok) begin
          start      = 1'b1;
          start_wave = ext_wave;
        end
      end
    endcase
  end

endmodule

// File: rtl/chirp_track_watchdog.sv
module chirp_track_watchdog #(
  parameter int WD_FRAMES = 5,
  localparam int CW = $clog2(WD_FRAMES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          track_mode,
  input  logic          hit,
  input  logic          frame_evt,
  output logic          fb_q,
  output logic          fb_now,
  output logic [CW-1:0] idle_cnt
);

  logic fire;

  assign fire   = track_mode && !hit && frame_evt && !fb_q &&
                  (idle_cnt == CW'(WD_FRAMES - 1));
  assign fb_now = fb_q || fire;

  always_ff @(posedge clk) begin
    if (!rst_n || !track_mode) begin
      idle_cnt <= '0;
      fb_q     <= 1'b0;
    end else if (hit) begin
      idle_cnt <= '0;
      fb_q     <= 1'b0;
    end else if (fire) begin
      idle_cnt <= '0;
      fb_q     <= 1'b1;
    end else if (frame_evt && !fb_q) begin
      idle_cnt <= idle_cnt + CW'(1);
    end
  end

endmodule

// File: rtl/chirp_sequencer.sv
module chirp_sequencer
  import chirp_seq_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int SHORT_DEF = 100,
  parameter int MED_DEF   = 500,
  parameter int LONG_DEF  = 1000,
  parameter int WD_FRAMES = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_sel,
  input  logic [2:0]       sub_en,
  input  logic             ext_req,
  input  logic [1:0]       ext_wave,
  input  logic             debug_go,
  input  logic             track_hit,
  input  logic [CNT_W-1:0] cfg_short_tx,
  input  logic [CNT_W-1:0] cfg_short_rx,
  input  logic [CNT_W-1:0] cfg_med_tx,
  input  logic [CNT_W-1:0] cfg_med_rx,
  input  logic [CNT_W-1:0] cfg_long_tx,
  input  logic [CNT_W-1:0] cfg_long_rx,
  output logic [1:0]       wave_sel,
  output logic             chirp_pulse,
  output logic             frame_end,
  output logic             scan_fallback
);

  localparam int WD_CW = $clog2(WD_FRAMES + 1);

  function automatic logic [CNT_W-1:0] tx_fix(input logic [CNT_W-1:0] cfg, input int def);
    return (cfg == '0) ? CNT_W'(def) : cfg;
  endfunction

  function automatic logic [CNT_W-1:0] rx_fix(input logic [CNT_W-1:0] cfg);
    return (cfg == '0) ? CNT_W'(1) : cfg;
  endfunction

  mode_t            md;
  wave_t            wave_q, start_wave_w;
  phase_t           phase_w;
  logic             sub_end_w, start_w, frame_evt_w, fb_q_w, fb_now_w;
  logic [CNT_W-1:0] tx_len_w, rx_len_w;
  logic [WD_CW-1:0] idle_cnt_w;
  logic             pulse_q, frame_q;

  assign md = mode_t'(mode_sel);

  always_comb begin
    case (start_wave_w)
      WV_MEDIUM: tx_len_w = tx_fix(cfg_med_tx, MED_DEF);
      WV_LONG:   tx_len_w = tx_fix(cfg_long_tx, LONG_DEF);
      default:   tx_len_w = tx_fix(cfg_short_tx, SHORT_DEF);
    endcase
    case (wave_q)
      WV_MEDIUM: rx_len_w = rx_fix(cfg_med_rx);
      WV_LONG:   rx_len_w = rx_fix(cfg_long_rx);
      default:   rx_len_w = rx_fix(cfg_short_rx);
    endcase
  end

  chirp_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .abort   (md == MD_PASS),
    .start   (start_w),
    .tx_len  (tx_len_w),
    .rx_len  (rx_len_w),
    .phase   (phase_w),
    .sub_end (sub_end_w)
  );

  chirp_wave_picker u_picker (
    .mode       (md),
    .sub_en     (sub_en),
    .ext_req    (ext_req),
    .ext_wave   (wave_t'(ext_wave)),
    .debug_go   (debug_go),
    .phase      (phase_w),
    .sub_end    (sub_end_w),
    .cur_wave   (wave_q),
    .fb_q       (fb_q_w),
    .fb_now     (fb_now_w),
    .start      (start_w),
    .start_wave (start_wave_w),
    .frame_evt  (frame_evt_w)
  );

  chirp_track_watchdog #(.WD_FRAMES(WD_FRAMES)) u_wd (
    .clk        (clk),
    .rst_n      (rst_n),
    .track_mode (md == MD_TRACK),
    .hit        (track_hit),
    .frame_evt  (frame_evt_w),
    .fb_q       (fb_q_w),
    .fb_now     (fb_now_w),
    .idle_cnt   (idle_cnt_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wave_q  <= WV_SHORT;
      pulse_q <= 1'b0;
      frame_q <= 1'b0;
    end else begin
      pulse_q <= start_w;
      frame_q <= frame_evt_w;
      if (start_w) wave_q <= start_wave_w;
    end
  end

  assign wave_sel      = wave_q;
  assign chirp_pulse   = pulse_q;
  assign frame_end     = frame_q;
  assign scan_fallback = fb_q_w;

endmodule

// File: rtl/chirp_sequencer_chk.sv
module chirp_sequencer_chk #(
  parameter int WD_FRAMES = 5,
  localparam int CW = $clog2(WD_FRAMES + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    mode_sel,
  input logic [2:0]    sub_en,
  input logic          ext_req,
  input logic [1:0]    ext_wave,
  input logic [1:0]    wave_sel,
  input logic          chirp_pulse,
  input logic          scan_fallback,
  input logic [1:0]    phase_w,
  input logic [CW-1:0] idle_cnt_w
);

  assert_wave_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wave_sel != 2'b11);

  assert_pass_echo_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b00 && ext_req && ext_wave != 2'b11)
    |=> (chirp_pulse && wave_sel == $past(ext_wave)));

  assert_pulse_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (chirp_pulse && phase_w == 2'd1 && mode_sel != 2'b00) |=> !chirp_pulse);

  assert_wave_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !chirp_pulse |-> $stable(wave_sel));

  assert_mask_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b01 && sub_en == 3'b000 && phase_w == 2'd0) |=> !chirp_pulse);

  assert_fallback_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
    scan_fallback |-> $past(mode_sel) == 2'b11);

  assert_idle_cnt_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    idle_cnt_w < CW'(WD_FRAMES));

endmodule

bind chirp_sequencer chirp_sequencer_chk #(.WD_FRAMES(WD_FRAMES)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .mode_sel      (mode_sel),
  .sub_en        (sub_en),
  .ext_req       (ext_req),
  .ext_wave      (ext_wave),
  .wave_sel      (wave_sel),
  .chirp_pulse   (chirp_pulse),
  .scan_fallback (scan_fallback),
  .phase_w       (phase_w),
  .idle_cnt_w    (idle_cnt_w)
);

// File: tb/tb_chirp_sequencer.sv
`timescale 1ns/1ps
module tb_chirp_sequencer;

  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [1:0]       mode_sel, ext_wave;
  logic [2:0]       sub_en;
  logic             ext_req, debug_go, track_hit;
  logic [CNT_W-1:0] s_tx, s_rx, m_tx, m_rx, l_tx, l_rx;
  logic [1:0]       wave_sel;
  logic             chirp_pulse, frame_end, scan_fallback;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  chirp_sequencer #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .sub_en(sub_en),
    .ext_req(ext_req), .ext_wave(ext_wave), .debug_go(debug_go),
    .track_hit(track_hit),
    .cfg_short_tx(s_tx), .cfg_short_rx(s_rx),
    .cfg_med_tx(m_tx), .cfg_med_rx(m_rx),
    .cfg_long_tx(l_tx), .cfg_long_rx(l_rx),
    .wave_sel(wave_sel), .chirp_pulse(chirp_pulse),
    .frame_end(frame_end), .scan_fallback(scan_fallback)
  );

  // {req, wave[1:0], exp_pulse, exp_wave[1:0]}
  localparam logic [5:0] PASS_VEC [0:7] = '{
    6'b1_01_1_01, 6'b1_10_1_10, 6'b0_00_0_10, 6'b1_11_0_10,
    6'b1_00_1_00, 6'b0_01_0_00, 6'b1_10_1_10, 6'b0_10_0_10
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_pulse(input int maxc, output int n);
    n = 0;
    do begin
      step();
      n++;
    end while (!chirp_pulse && n < maxc);
  endtask

  task automatic count_pulses(input int cyc, output int cnt);
    cnt = 0;
    for (int i = 0; i < cyc; i++) begin
      step();
      if (chirp_pulse) cnt++;
    end
  endtask

  task automatic set_cfg_small();
    s_tx = 2; s_rx = 3;   // short period 5
    m_tx = 4; m_rx = 2;   // medium period 6
    l_tx = 3; l_rx = 4;   // long period 7
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    int cnt;
    rst_n = 1'b0; mode_sel = 2'b00; ext_req = 1'b1; ext_wave = 2'b01;
    sub_en = 3'b111; debug_go = 1'b0; track_hit = 1'b0;
    set_cfg_small();
    step(); step(); step();
    // R1: held in reset despite an active request
    chk("R1 pulse in reset", chirp_pulse, 0);
    chk("R1 wave in reset", wave_sel, 0);
    chk("R1 frame_end in reset", frame_end, 0);
    chk("R1 fallback in reset", scan_fallback, 0);
    ext_req = 1'b0;
    rst_n = 1'b1;
    step();
    chk("R1 idle after reset", chirp_pulse, 0);

    // R3 / R2: forwarding table, mask cleared to show it has no effect
    sub_en = 3'b000;
    foreach (PASS_VEC[i]) begin
      ext_req  = PASS_VEC[i][5];
      ext_wave = PASS_VEC[i][4:3];
      step();
      chk("R3 forwarded pulse", chirp_pulse, PASS_VEC[i][2]);
      chk("R3/R2 forwarded wave", wave_sel, PASS_VEC[i][1:0]);
    end
    ext_req = 1'b0;

    // R6 / R5 / R9: scan over all three
    sub_en = 3'b111; mode_sel = 2'b01;
    wait_pulse(50, n); chk("R6 scan starts at once", n, 1); chk("R6 first short", wave_sel, 0);
    wait_pulse(50, n); chk("R5 short period", n, 5); chk("R6 then medium", wave_sel, 1);
    chk("R9 no frame_end mid-pass", frame_end, 0);
    wait_pulse(50, n); chk("R5 medium period", n, 6); chk("R6 then long", wave_sel, 2);
    wait_pulse(50, n); chk("R5 long period", n, 7); chk("R6 wraps to short", wave_sel, 0);
    chk("R9 frame_end after long", frame_end, 1);
    step(); chk("R9 frame_end one cycle", frame_end, 0);
    // drop medium during the short sub-frame
    sub_en = 3'b101;
    wait_pulse(50, n); chk("R6 masked skip period", n, 4); chk("R6 medium skipped", wave_sel, 2);
    wait_pulse(50, n); chk("R5 long period again", n, 7); chk("R6 back to short", wave_sel, 0);
    // R7: all disabled
    sub_en = 3'b000;
    count_pulses(40, cnt); chk("R7 no pulses with empty mask", cnt, 0);

    // R5: zero lengths select defaults
    s_tx = 0; s_rx = 1; m_tx = 0; m_rx = 1;
    sub_en = 3'b001;
    wait_pulse(50, n); chk("R5 default short start", n, 1);
    wait_pulse(2000, n); chk("R5 default short length", n, 101);
    sub_en = 3'b010;
    wait_pulse(2000, n); chk("R5 short then medium", n, 101); chk("R6 medium only", wave_sel, 1);
    wait_pulse(2000, n); chk("R5 default medium length", n, 501);
    sub_en = 3'b000; mode_sel = 2'b00;
    step();
    set_cfg_small();

    // R8: single debug chirp
    mode_sel = 2'b10; ext_wave = 2'b10;
    debug_go = 1'b1; step(); debug_go = 1'b0;
    chk("R8 debug pulse", chirp_pulse, 1); chk("R8 debug wave", wave_sel, 2);
    step(); debug_go = 1'b1; step(); debug_go = 1'b0;
    count_pulses(30, cnt); chk("R8 one chirp, busy trigger ignored", cnt, 0);
    debug_go = 1'b1; step(); debug_go = 1'b0;
    chk("R8 re-trigger from idle", chirp_pulse, 1);
    repeat (20) step();
    ext_wave = 2'b11; debug_go = 1'b1; step(); debug_go = 1'b0;
    chk("R2 reserved wave starts nothing", chirp_pulse, 0);
    chk("R2 wave held", wave_sel, 2);

    // R10 / R9: track dwell on medium, watchdog fallback
    mode_sel = 2'b00; step();
    ext_wave = 2'b01; sub_en = 3'b111; mode_sel = 2'b11;
    wait_pulse(50, n); chk("R10 dwell starts", n, 1); chk("R10 dwell wave", wave_sel, 1);
    for (int k = 1; k <= 4; k++) begin
      wait_pulse(50, n);
      chk("R10 dwell period", n, 6);
      chk("R9 dwell frame_end", frame_end, 1);
      chk("R10 no fallback yet", scan_fallback, 0);
    end
    wait_pulse(50, n); chk("R10 fifth frame period", n, 6);
    chk("R10 fallback rises", scan_fallback, 1); chk("R10 scan after medium", wave_sel, 2);
    wait_pulse(50, n); chk("R10 fallback scan period", n, 7); chk("R10 scan wraps", wave_sel, 0);
    track_hit = 1'b1; step(); track_hit = 1'b0;
    chk("R10 hit clears fallback", scan_fallback, 0);
    wait_pulse(50, n); chk("R10 resume period", n, 4); chk("R10 resume dwell", wave_sel, 1);

    // R10: hit restarts the idle-frame count
    mode_sel = 2'b00; step();
    ext_wave = 2'b00; mode_sel = 2'b11;
    wait_pulse(50, n); chk("R10 dwell short start", n, 1);
    for (int k = 1; k <= 3; k++) begin
      wait_pulse(50, n); chk("R10 short dwell period", n, 5);
    end
    track_hit = 1'b1; step(); track_hit = 1'b0;
    wait_pulse(50, n); chk("R10 period after hit", n, 4);
    for (int k = 5; k <= 7; k++) begin
      wait_pulse(50, n);
      chk("R10 count restarted by hit", scan_fallback, 0);
    end
    wait_pulse(50, n); chk("R10 fallback after five idle", scan_fallback, 1);
    chk("R10 scan after short", wave_sel, 1);
    mode_sel = 2'b01; step();
    chk("R10 leaving track clears fallback", scan_fallback, 0);

    // R1: reset in the middle of a scan
    rst_n = 1'b0; step(); step();
    chk("R1 mid-run reset pulse", chirp_pulse, 0);
    chk("R1 mid-run reset wave", wave_sel, 0);
    rst_n = 1'b1; mode_sel = 2'b00; step();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule